// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Strobe Generator

This block produces the address latch enable (ALE) strobe for an external memory bus and drives the shared 8-bit port on which the address and the data take turns. A bus cycle is four periods of the oscillator clock. ALE rises at the start of the cycle and falls halfway through the second period. Forming that half-period edge needs a flop on the falling clock edge next to the rising-edge phase counter.

While ALE is high, the port carries the low byte of the address so that an external transparent latch can hold it. After ALE falls, the port becomes the data bus:
- For a write, the block drives the data byte until the cycle ends.
- For a read, the block releases the port and samples it on the clock edge that closes the cycle.

When no access is running, the port behaves as an open-drain output. It pulls low only the bits whose I/O latch bit is 0. A disable input holds ALE high while the bus is idle. That input has no effect while an access is running.

States and transitions:
- The phase register steps T0 → T1 → T2 → T3 → T0 on every rising clock edge.
- The cycle register holds IDLE, READ or WRITE. It is reloaded only on the edge that leaves T3:
  - to READ or WRITE when a request is present, according to the request's write flag;
  - to IDLE when no request is present.
- Every state can take every one of these transitions, so accesses can follow one another back to back.

Top module: `mux_bus_strobe`

## Requirements
- R1: With the block out of reset and the strobe not suppressed, `ale` rises on the rising clock edge that enters phase T0 and repeats every 4 clock periods; `req_ready` is 1 exactly during phase T3.
- R2: `ale` stays high for 1.5 clock periods and falls on the falling clock edge in the middle of phase T1; it is low for the rest of T1, T2 and T3.
- R3: While `rst_n` is 0, `ale` is 1, `port_oe` is all zeros and `busy` is 0, at once and whatever the phase.
- R4: When `ale_off` is 1 and no access is running, `ale` stays 1 at every sample point.
- R5: During an access, `ale` pulses with the timing of R1 and R2 even when `ale_off` is 1.
- R6: During an access, while `ale` is high, `port_out` equals the request address byte and `port_oe` is all ones, so a latch transparent on high `ale` holds that byte after `ale` falls.
- R7: In a write cycle, from the fall of `ale` to the end of T3, `port_out` equals the write data and `port_oe` is all ones.
- R8: In a read cycle, `port_oe` is all zeros from the fall of `ale` to the end of T3. `port_in` is sampled on the rising edge that leaves T3 into `rd_data`, and `rd_valid` is 1 for the one period that follows.
- R9: A request (`req_valid` = 1) is taken only on the rising edge that leaves T3. A request raised in another phase leaves `busy` at 0 until that edge. `busy` is 1 through T0 to T3 of an accepted cycle, and a request held across the boundary starts the next cycle with no idle gap.
- R10: With no access running and out of reset, each bit of `port_oe` is the inverse of the matching `io_latch` bit and `port_out` is 0. A port bit is pulled low only when its latch bit is 0, and is otherwise left floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_off | input | 1 | Holds ALE high while the bus is idle |
| io_latch | input | 8 | Port output latch for plain I/O mode (0 = pull low) |
| req_valid | input | 1 | Access request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Low byte of the access address |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | High during T3, when a request can be taken |
| busy | output | 1 | An access cycle is running |
| ale | output | 1 | Address latch enable strobe |
| port_out | output | 8 | Value driven onto the shared port |
| port_oe | output | 8 | Per-bit output enable of the shared port |
| port_in | input | 8 | Value seen on the shared port |
| rd_data | output | 8 | Byte captured at the end of a read |
| rd_valid | output | 1 | `rd_data` updated in the previous edge |

## Verification
The assertions check the following on every clock:
- `ale` is high at the end of T0 and low in T2 of an access.
- While `ale_off` is set and the bus is idle, `ale` stays high.
- `busy` rises only after T3.
- The address is driven in T0 and the write data in T2.
- The port is released in the data half of a read.
- `rd_valid` follows only a read's T3.

Only the bench scenarios can show the following:
- The exact half-period position of the falling edge, sampled between clock edges.
- That the external latch holds the address.
- The values carried by read data.
- The open-drain pattern in idle.
- The behaviour of reset asserted partway through a cycle.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

    // One bus cycle spans four oscillator periods.
    typedef enum logic [1:0] {
        PH_T0 = 2'd0,
        PH_T1 = 2'd1,
        PH_T2 = 2'd2,
        PH_T3 = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_t;

endpackage

// File: rtl/strobe_timer.sv
module strobe_timer
    import mux_bus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ale_off,
    input  logic   busy,
    output phase_t phase,
    output logic   addr_window,
    output logic   ale_o
);

    phase_t phase_nxt;
    logic   half_late;   // set on the falling edge inside T1

    always_comb begin
        unique case (phase)
            PH_T0:   phase_nxt = PH_T1;
            PH_T1:   phase_nxt = PH_T2;
            PH_T2:   phase_nxt = PH_T3;
            PH_T3:   phase_nxt = PH_T0;
            default: phase_nxt = PH_T0;
        endcase
    end

    // Reset to T3 so the first edge after reset opens a cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_T3;
        end else begin
            phase <= phase_nxt;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_late <= 1'b0;
        end else begin
            half_late <= (phase == PH_T1);
        end
    end

    // High for T0 and the first half of T1: 1.5 periods.
    assign addr_window = (phase == PH_T0) || ((phase == PH_T1) && !half_late);

    always_comb begin
        if (!rst_n) begin
            ale_o = 1'b1;
        end else if (ale_off && !busy) begin
            ale_o = 1'b1;
        end else begin
            ale_o = addr_window;
        end
    end

    AST_ALE_HIGH_T0: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T0) |-> ale_o);                        // R1

    AST_ALE_LOW_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_T2) |-> !ale_o);               // R2

    AST_IDLE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_off && !busy) |-> ale_o);                      // R4

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import mux_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output cyc_t              cyc,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              ready,
    output logic              busy
);

    cyc_t cyc_nxt;
    cyc_t req_kind;

    assign req_kind = req_wr ? CYC_WRITE : CYC_READ;
    assign ready    = (phase == PH_T3);

    always_comb begin
        cyc_nxt = cyc;
        if (phase == PH_T3) begin
            unique case (cyc)
                CYC_IDLE:  cyc_nxt = req_valid ? req_kind : CYC_IDLE;
                CYC_READ:  cyc_nxt = req_valid ? req_kind : CYC_IDLE;
                CYC_WRITE: cyc_nxt = req_valid ? req_kind : CYC_IDLE;
                default:   cyc_nxt = CYC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= CYC_IDLE;
        end else begin
            cyc <= cyc_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (phase == PH_T3 && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign busy = (cyc != CYC_IDLE);

    AST_BUSY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(phase) == PH_T3));           // R9

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_T3) |-> $stable(cyc));          // R9

endmodule

// File: rtl/port_driver.sv
module port_driver
    import mux_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              addr_window,
    input  cyc_t              cyc,
    input  logic [DATA_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [DATA_W-1:0] io_latch,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] port_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam logic [DATA_W-1:0] ALL_ON  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] ALL_OFF = {DATA_W{1'b0}};

    logic capture;

    always_comb begin
        port_out = ALL_OFF;
        port_oe  = ALL_OFF;
        if (rst_n) begin
            unique case (cyc)
                CYC_IDLE: begin
                    // Open-drain: drive low only where the latch holds 0.
                    port_out = ALL_OFF;
                    port_oe  = ~io_latch;
                end
                CYC_READ: begin
                    port_out = addr_window ? addr_q : ALL_OFF;
                    port_oe  = addr_window ? ALL_ON : ALL_OFF;
                end
                CYC_WRITE: begin
                    port_out = addr_window ? addr_q : wdata_q;
                    port_oe  = ALL_ON;
                end
                default: begin
                    port_out = ALL_OFF;
                    port_oe  = ALL_OFF;
                end
            endcase
        end
    end

    assign capture = (phase == PH_T3) && (cyc == CYC_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= port_in;
            end
        end
    end

    AST_ADDR_IN_T0: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != CYC_IDLE && phase == PH_T0) |-> (port_out == addr_q && port_oe == ALL_ON)); // R6

    AST_WR_DATA_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE && phase == PH_T2) |-> (port_out == wdata_q && port_oe == ALL_ON)); // R7

    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_READ && (phase == PH_T2 || phase == PH_T3)) |-> (port_oe == ALL_OFF)); // R8

    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cyc) == CYC_READ && $past(phase) == PH_T3)); // R8

endmodule

// File: rtl/mux_bus_strobe.sv
module mux_bus_strobe
    import mux_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_off,
    input  logic [DATA_W-1:0] io_latch,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic              ale,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] port_oe,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    phase_t            phase;
    logic              addr_window;
    cyc_t              cyc;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    strobe_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ale_off     (ale_off),
        .busy        (busy),
        .phase       (phase),
        .addr_window (addr_window),
        .ale_o       (ale)
    );

    cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cyc       (cyc),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .ready     (req_ready),
        .busy      (busy)
    );

    port_driver #(.DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .addr_window (addr_window),
        .cyc         (cyc),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .io_latch    (io_latch),
        .port_in     (port_in),
        .port_out    (port_out),
        .port_oe     (port_oe),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

endmodule

// File: tb/sim_mux_bus_strobe.sv
`timescale 1ns/1ps
module sim_mux_bus_strobe;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale_off = 1'b0;
    logic [7:0] io_latch = 8'h0F;
    logic       req_valid = 1'b0;
    logic       req_wr = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       req_ready, busy, ale, rd_valid;
    logic [7:0] port_out, port_oe, port_in, rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] ext_latch = 8'h00;
    logic       s_ale  [8];
    logic       s_busy [8];
    logic [7:0] s_out  [8];
    logic [7:0] s_oe   [8];

    always #4 clk = ~clk;   // 125 MHz

    mux_bus_strobe u0 (
        .clk(clk), .rst_n(rst_n), .ale_off(ale_off), .io_latch(io_latch),
        .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .busy(busy), .ale(ale),
        .port_out(port_out), .port_oe(port_oe), .port_in(port_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // External transparent latch: follows the port while ALE is high.
    always @(posedge clk or negedge clk) begin
        if (ale) ext_latch <= port_out;
    end

    // External memory model: byte = latched address ^ 8'hA5.
    assign port_in = ext_latch ^ 8'hA5;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Leave at the middle of phase T3 (1 ns after the falling edge).
    task automatic wait_t3();
        do begin
            @(negedge clk); #1;
        end while (!req_ready);
    endtask

    // Called in mid T3; samples 1 ns after each of the next 8 clock edges.
    task automatic run_cycle(input bit with_req, input bit wr,
                             input logic [7:0] a, input logic [7:0] d);
        if (with_req) begin
            req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        end
        for (int i = 0; i < 8; i++) begin
            if (i % 2 == 0) @(posedge clk); else @(negedge clk);
            #1;
            s_ale[i] = ale; s_busy[i] = busy; s_out[i] = port_out; s_oe[i] = port_oe;
            if (i == 0) req_valid = 1'b0;
        end
    endtask

    task automatic check_ale_shape(input string tag);
        for (int i = 0; i < 8; i++) begin
            chk(s_ale[i] == (i < 3), tag, s_ale[i], (i < 3));
        end
    endtask

    task automatic t_reset();
        #1;
        chk(ale == 1'b1, "R3 ale in reset", ale, 1);
        chk(port_oe == 8'h00, "R3 oe in reset", port_oe, 0);
        chk(busy == 1'b0, "R3 busy in reset", busy, 0);
    endtask

    task automatic t_free_pulse();
        ale_off = 1'b0; io_latch = 8'h0F;
        wait_t3();
        run_cycle(1'b0, 1'b0, 8'h00, 8'h00);
        check_ale_shape("R1 R2 idle pulse");
        for (int i = 0; i < 8; i++) begin
            chk(s_oe[i] == 8'hF0 && s_out[i] == 8'h00, "R10 open drain",
                {s_out[i], s_oe[i]}, 16'h00F0);
            chk(s_busy[i] == 1'b0, "R9 idle busy", s_busy[i], 0);
        end
    endtask

    task automatic t_suppress_idle();
        ale_off = 1'b1;
        wait_t3();
        run_cycle(1'b0, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++) begin
            chk(s_ale[i] == 1'b1, "R4 idle suppressed", s_ale[i], 1);
        end
    endtask

    task automatic t_write();
        ale_off = 1'b1;
        wait_t3();
        run_cycle(1'b1, 1'b1, 8'h3C, 8'hC3);
        check_ale_shape("R5 write pulse");
        for (int i = 0; i < 8; i++) begin
            chk(s_busy[i] == 1'b1, "R9 busy write", s_busy[i], 1);
            chk(s_oe[i] == 8'hFF, "R6 R7 oe write", s_oe[i], 8'hFF);
            if (i < 3) chk(s_out[i] == 8'h3C, "R6 address", s_out[i], 8'h3C);
            else       chk(s_out[i] == 8'hC3, "R7 write data", s_out[i], 8'hC3);
        end
        chk(ext_latch == 8'h3C, "R6 latched address", ext_latch, 8'h3C);
        ale_off = 1'b0;
    endtask

    task automatic t_read();
        wait_t3();
        run_cycle(1'b1, 1'b0, 8'h81, 8'h00);
        check_ale_shape("R2 read pulse");
        for (int i = 0; i < 8; i++) begin
            if (i < 3) chk(s_oe[i] == 8'hFF && s_out[i] == 8'h81, "R6 read address",
                           {s_out[i], s_oe[i]}, 16'h81FF);
            else       chk(s_oe[i] == 8'h00, "R8 released", s_oe[i], 0);
        end
        @(posedge clk); #1;
        chk(rd_valid == 1'b1, "R8 rd_valid", rd_valid, 1);
        chk(rd_data == (8'h81 ^ 8'hA5), "R8 rd_data", rd_data, 8'h81 ^ 8'hA5);
        @(posedge clk); #1;
        chk(rd_valid == 1'b0, "R8 rd_valid one period", rd_valid, 0);
    endtask

    task automatic t_boundary();
        wait_t3();
        @(posedge clk); #1;                    // T0, idle
        @(posedge clk); #1;                    // T1
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 8'h44;
        chk(req_ready == 1'b0, "R1 ready low in T1", req_ready, 0);
        @(posedge clk); #1;                    // T2
        chk(busy == 1'b0, "R9 not taken in T1", busy, 0);
        @(posedge clk); #1;                    // T3
        chk(busy == 1'b0 && req_ready == 1'b1, "R9 waits for T3", {busy, req_ready}, 2'b01);
        @(posedge clk); #1;                    // T0 of the new cycle
        chk(busy == 1'b1 && port_out == 8'h44, "R9 taken at boundary",
            {busy, port_out}, 9'h144);
        req_valid = 1'b0;
        wait_t3();
        @(posedge clk); #1;
        chk(rd_valid && rd_data == (8'h44 ^ 8'hA5), "R8 boundary read data",
            rd_data, 8'h44 ^ 8'hA5);
    endtask

    task automatic t_back_to_back();
        wait_t3();
        req_valid = 1'b1; req_wr = 1'b1; req_addr = 8'hA1; req_wdata = 8'h11;
        @(posedge clk); #1;
        chk(busy == 1'b1 && port_out == 8'hA1, "R9 first cycle", {busy, port_out}, 9'h1A1);
        req_addr = 8'hB2; req_wdata = 8'h22;
        wait_t3();
        chk(port_out == 8'h11, "R7 first data", port_out, 8'h11);
        @(posedge clk); #1;
        chk(busy == 1'b1 && port_out == 8'hB2 && ale == 1'b1, "R9 back to back",
            {ale, busy, port_out}, 10'h3B2);
        req_valid = 1'b0;
        wait_t3();
        chk(port_out == 8'h22 && busy == 1'b1, "R7 second data", {busy, port_out}, 9'h122);
        @(posedge clk); #1;
        chk(busy == 1'b0, "R9 ends", busy, 0);
    endtask

    task automatic t_reset_mid();
        wait_t3();
        req_valid = 1'b1; req_wr = 1'b1; req_addr = 8'h5A; req_wdata = 8'h77;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;                    // T1
        @(negedge clk); #1;                    // ALE low, data driven
        rst_n = 1'b0;
        #1;
        chk(ale == 1'b1 && port_oe == 8'h00 && busy == 1'b0, "R3 reset mid cycle",
            {ale, busy, port_oe}, 10'h200);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_free_pulse();
        t_suppress_idle();
        t_write();
        t_read();
        t_boundary();
        t_back_to_back();
        t_reset_mid();
        t_free_pulse();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule